// File: doc/BRIEF.md
# Edge-Triggered Prioritized Interrupt Combiner

This block collects interrupt events from six sources and turns them into two request lines for a processor, one for high priority and one for low priority, plus a wake-up line for leaving a power-managed state. The sources are four asynchronous external pins, each with its own choice of rising or falling edge, a one-cycle timer overflow pulse produced elsewhere, and a change detector watching four more asynchronous port inputs. Each source latches a sticky flag whenever its event occurs, whether or not the source is enabled. Software then uses the flags, per-source enables and priority bits to decide what reaches the processor.

Source indices are fixed: 0 to 3 are the external pins, 4 is the timer overflow and 5 is the port-change detector. Pin 0 always routes to the high-priority request. Every other source has a priority bit. Two global gates, one per request line, sit after the per-source masking. The wake-up line ignores both gates and follows only the external sources' flags and enables.

A simple synchronous register port gives access to the state. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `irq_combiner`

## Requirements
- R1: Each external pin i (0..3) has an edge-select bit, bit i of the control register (address 0): 1 selects rising, 0 selects falling. A selected edge sets flag bit i of the flag register (address 3) on the third rising clock edge after the pin changes. The opposite edge leaves the flag unchanged.
- R2: A set flag stays set until a write to address 3 carries a 0 in that bit. A 1 written to a flag bit leaves it unchanged, and no write can set a flag.
- R3: The enable register (address 1) holds one enable bit per source at the source's index. A flag whose enable is 0 still latches, but it reaches neither `irq_hi` nor `irq_lo`.
- R4: The priority register (address 2) uses bits 1..5 (1 = high, 0 = low). Bit 0 always reads 0 and pin 0 always routes to `irq_hi`.
- R5: `wake` is high exactly when some external source (0..3) has both its flag and its enable set. It does not depend on either global gate, and the timer and port-change sources never drive it.
- R6: A one-cycle high pulse on `tmr_ovf` sets flag bit 4 at the same clock edge.
- R7: A change on any bit of `port_in` sets flag bit 5 on the third rising clock edge after the change. A simultaneous change on several bits yields one flag.
- R8: Control bit 4 gates `irq_hi` and control bit 5 gates `irq_lo`. Either request is high only when its gate is set and an enabled flag of its priority class is set.
- R9: When a flag's set event and a software clear of that flag fall on the same clock edge, the flag ends set.
- R10: After reset, all registers read 0 and `irq_hi`, `irq_lo` and `wake` are low.
- R11: The control, enable and priority registers read back the values written, limited to their defined bits (control 5:0, enable 5:0, priority 5:1). Undefined bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 4 | Asynchronous external interrupt pins |
| port_in | input | 4 | Asynchronous port inputs watched for change |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_hi | output | 1 | High-priority request to the processor |
| irq_lo | output | 1 | Low-priority request to the processor |
| wake | output | 1 | Wake-up request from power-managed state |

## Verification
The hardest case to reach from the ports is a set event and a software clear landing on the same clock edge for the same flag. Asynchronous pin events pass through the synchronizer, so their arrival edge is awkward to line up. The bench instead uses the timer pulse, which sets its flag at the edge where it is sampled. It raises the pulse in the same half-cycle as a flag-clear write and then reads the flag back. The timing of the other sources is pinned down by reading the flag register one edge before and one edge after the expected latch point.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int N_EXT   = 4;
    localparam int N_CHG   = 4;
    localparam int DW      = 8;
    localparam int AW      = 2;
    localparam int NSRC    = N_EXT + 2;
    localparam int TMR_IDX = N_EXT;
    localparam int CHG_IDX = N_EXT + 1;
    localparam int GHI_BIT = N_EXT;
    localparam int GLO_BIT = N_EXT + 1;

    typedef enum logic [AW-1:0] {
        REG_CTRL = 2'd0,
        REG_EN   = 2'd1,
        REG_PRIO = 2'd2,
        REG_FLAG = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [N_EXT-1:0] edge_rise;
        logic             gate_hi;
        logic             gate_lo;
        logic [NSRC-1:0]  en;
        logic [NSRC-1:0]  prio;
        logic [NSRC-1:0]  flags;
    } ctl_state_t;

endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     cur;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        cur       = st_q.sync[STAGES-1];
        st_d.prev = cur;
        hit       = rise_sel ? (cur & ~st_q.prev) : (~cur & st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port,
    output logic             hit
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] sync;
        logic [WIDTH-1:0]             last;
    } chg_st_t;

    chg_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = port;
        for (int s = 1; s < STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        // compare first, then refresh the latch with the compared sample
        hit       = |(st_q.sync[STAGES-1] ^ st_q.last);
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int NSRC  = 6,
    parameter int N_EXT = 4
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] prio,
    input  logic            gate_hi,
    input  logic            gate_lo,
    output logic            irq_hi,
    output logic            irq_lo,
    output logic            wake
);

    localparam logic [NSRC-1:0] FIXED_HI = {{(NSRC-1){1'b0}}, 1'b1};

    logic [NSRC-1:0] live;
    logic [NSRC-1:0] route_hi;

    always_comb begin
        live     = flags & en;
        route_hi = prio | FIXED_HI;
        irq_hi   = gate_hi & |(live & route_hi);
        irq_lo   = gate_lo & |(live & ~route_hi);
        wake     = |live[N_EXT-1:0];
    end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_in,
    input  logic [N_CHG-1:0]  port_in,
    input  logic              tmr_ovf,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic              wake
);

    localparam logic [NSRC-1:0] PRIO_MASK = {{(NSRC-1){1'b1}}, 1'b0};

    ctl_state_t       st_d, st_q;
    logic [N_EXT-1:0] ext_hit;
    logic             chg_hit;
    logic [NSRC-1:0]  set_vec;
    logic [NSRC-1:0]  clr_vec;
    logic [NSRC-1:0]  flag_vec;
    logic [NSRC-1:0]  en_vec;
    logic             gate_hi;
    logic             gate_lo;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        irq_ext_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (ext_in[g]),
            .rise_sel (st_q.edge_rise[g]),
            .hit      (ext_hit[g])
        );
    end

    irq_port_change #(
        .WIDTH  (N_CHG),
        .STAGES (SYNC_STAGES)
    ) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .port  (port_in),
        .hit   (chg_hit)
    );

    always_comb begin
        st_d    = st_q;
        set_vec = '0;
        set_vec[N_EXT-1:0] = ext_hit;
        set_vec[TMR_IDX]   = tmr_ovf;
        set_vec[CHG_IDX]   = chg_hit;
        clr_vec = '0;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_CTRL: begin
                    st_d.edge_rise = wr_data[N_EXT-1:0];
                    st_d.gate_hi   = wr_data[GHI_BIT];
                    st_d.gate_lo   = wr_data[GLO_BIT];
                end
                REG_EN:   st_d.en   = wr_data[NSRC-1:0];
                REG_PRIO: st_d.prio = wr_data[NSRC-1:0] & PRIO_MASK;
                REG_FLAG: clr_vec   = ~wr_data[NSRC-1:0];
                default:  ;
            endcase
        end
        // a set in the same cycle as a clear wins
        st_d.flags = (st_q.flags & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            REG_CTRL: begin
                rd_data[N_EXT-1:0] = st_q.edge_rise;
                rd_data[GHI_BIT]   = st_q.gate_hi;
                rd_data[GLO_BIT]   = st_q.gate_lo;
            end
            REG_EN:   rd_data[NSRC-1:0] = st_q.en;
            REG_PRIO: rd_data[NSRC-1:0] = st_q.prio;
            REG_FLAG: rd_data[NSRC-1:0] = st_q.flags;
            default:  rd_data = '0;
        endcase
    end

    assign flag_vec = st_q.flags;
    assign en_vec   = st_q.en;
    assign gate_hi  = st_q.gate_hi;
    assign gate_lo  = st_q.gate_lo;

    irq_route #(
        .NSRC  (NSRC),
        .N_EXT (N_EXT)
    ) u_route (
        .flags   (st_q.flags),
        .en      (st_q.en),
        .prio    (st_q.prio),
        .gate_hi (st_q.gate_hi),
        .gate_lo (st_q.gate_lo),
        .irq_hi  (irq_hi),
        .irq_lo  (irq_lo),
        .wake    (wake)
    );

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic            tmr_ovf,
    input logic [NSRC-1:0] flag_vec,
    input logic [NSRC-1:0] en_vec,
    input logic            gate_hi,
    input logic            gate_lo,
    input logic            irq_hi,
    input logic            irq_lo,
    input logic            wake
);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_en) && ($past(wr_addr) == 2'd3)) |-> ((flag_vec & $past(flag_vec)) == $past(flag_vec))); // R2

    AST_REQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi || irq_lo) |-> ((flag_vec & en_vec) != '0)); // R3

    AST_PIN0_ALWAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec[0] && en_vec[0] && gate_hi) |-> irq_hi); // R4

    AST_WAKE_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_vec[N_EXT-1:0] & en_vec[N_EXT-1:0]) != '0) |-> wake); // R5

    AST_WAKE_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ((flag_vec[N_EXT-1:0] & en_vec[N_EXT-1:0]) != '0)); // R5

    AST_TMR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmr_ovf) && $past(rst_n)) |-> flag_vec[TMR_IDX]); // R6

    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> gate_hi); // R8

    AST_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> gate_lo); // R8

endmodule

bind irq_combiner irq_combiner_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .tmr_ovf  (tmr_ovf),
    .flag_vec (flag_vec),
    .en_vec   (en_vec),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .irq_hi   (irq_hi),
    .irq_lo   (irq_lo),
    .wake     (wake)
);

// File: tb/sim_irq_combiner.sv
module sim_irq_combiner;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_in = '0;
    logic [3:0] port_in = '0;
    logic       tmr_ovf = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_hi, irq_lo, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] ctrl_sh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_combiner u0 (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .port_in(port_in),
        .tmr_ovf(tmr_ovf), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_hi(irq_hi), .irq_lo(irq_lo),
        .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) ctrl_sh = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic flag_bit(input int i, output logic b);
        logic [7:0] v;
        rd(2'd3, v);
        b = v[i];
    endtask

    // drive pin i to val; check flag before and at the third edge
    task automatic pin_step(input int i, input logic val, input logic exp_set, input string req);
        logic b;
        @(negedge clk);
        ext_in[i] = val;
        repeat (2) @(negedge clk);
        flag_bit(i, b);
        chk({req, " flag not yet latched"}, b, 1'b0);
        @(negedge clk);
        flag_bit(i, b);
        chk({req, " flag after third edge"}, b, exp_set);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R10 register reset value", v, 8'h00);
        end
        chk("R10 outputs after reset", {irq_hi, irq_lo, wake}, 3'b000);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R11 ctrl readback", v, 8'h3F);
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R11 enable readback", v, 8'h3F);
        wr(2'd2, 8'hFF); rd(2'd2, v); chk("R4 prio bit0 reads zero", v, 8'h3E);
        wr(2'd2, 8'h15); rd(2'd2, v); chk("R11 prio pattern", v, 8'h14);
        wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 software cannot set flags", v, 8'h00);
        chk("R3 no request without flags", {irq_hi, irq_lo, wake}, 3'b000);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_ext_edges;
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, ctrl_sh | 8'(1 << i));
            pin_step(i, 1'b1, 1'b1, "R1 rising edge sets");
            wr(2'd3, 8'h00);
            pin_step(i, 1'b0, 1'b0, "R1 falling ignored in rising mode");
            wr(2'd0, ctrl_sh & ~8'(1 << i));
            pin_step(i, 1'b1, 1'b0, "R1 rising ignored in falling mode");
            pin_step(i, 1'b0, 1'b1, "R1 falling edge sets");
            wr(2'd3, 8'h00);
        end
    endtask

    task automatic t_sticky;
        logic [7:0] v;
        wr(2'd0, 8'h04);
        pin_step(2, 1'b1, 1'b1, "R1 pin2 rising");
        repeat (5) @(negedge clk);
        rd(2'd3, v); chk("R2 flag stays set", v, 8'h04);
        wr(2'd3, 8'h04); rd(2'd3, v); chk("R2 writing one keeps flag", v, 8'h04);
        wr(2'd3, 8'hFB); rd(2'd3, v); chk("R2 writing zero clears flag", v, 8'h00);
        pin_step(2, 1'b0, 1'b0, "R1 pin2 falling ignored");
        wr(2'd0, 8'h00);
    endtask

    task automatic t_enable_prio;
        logic [7:0] v;
        wr(2'd0, 8'h32);  // gates on, pin1 rising
        pin_step(1, 1'b1, 1'b1, "R1 pin1 rising");
        rd(2'd3, v); chk("R3 flag latches while disabled", v, 8'h02);
        chk("R3 disabled source silent", {irq_hi, irq_lo, wake}, 3'b000);
        wr(2'd1, 8'h02);
        chk("R4 pin1 low priority", {irq_hi, irq_lo, wake}, 3'b011);
        wr(2'd2, 8'h02);
        chk("R4 pin1 high priority", {irq_hi, irq_lo, wake}, 3'b101);
        wr(2'd0, 8'h02);
        chk("R5 wake without global gates", {irq_hi, irq_lo, wake}, 3'b001);
        wr(2'd1, 8'h00);
        chk("R5 wake needs enable", wake, 1'b0);
        wr(2'd3, 8'h00);
        @(negedge clk); ext_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    endtask

    task automatic t_pin0;
        wr(2'd0, 8'h31);
        pin_step(0, 1'b1, 1'b1, "R1 pin0 rising");
        wr(2'd1, 8'h01);
        chk("R4 pin0 high with prio zero", {irq_hi, irq_lo}, 2'b10);
        wr(2'd0, 8'h21);
        chk("R8 hi gate off", {irq_hi, irq_lo, wake}, 3'b001);
        wr(2'd3, 8'h00);
        chk("R2 cleared pin0 drops requests", {irq_hi, irq_lo, wake}, 3'b000);
        @(negedge clk); ext_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_timer;
        logic [7:0] v;
        wr(2'd0, 8'h20); wr(2'd1, 8'h10);
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        rd(2'd3, v); chk("R6 timer flag next edge", v, 8'h10);
        chk("R5 timer low request no wake", {irq_hi, irq_lo, wake}, 3'b010);
        wr(2'd0, 8'h00);
        chk("R8 lo gate off", irq_lo, 1'b0);
        wr(2'd2, 8'h10); wr(2'd0, 8'h10);
        chk("R8 timer high route", {irq_hi, irq_lo}, 2'b10);
        wr(2'd3, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_set_wins;
        logic [7:0] v;
        @(negedge clk);
        tmr_ovf = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
        @(negedge clk);
        tmr_ovf = 1'b0; wr_en = 1'b0;
        rd(2'd3, v); chk("R9 set beats clear", v, 8'h10);
        wr(2'd3, 8'h00); rd(2'd3, v); chk("R2 later clear works", v, 8'h00);
    endtask

    task automatic t_port_change;
        logic [7:0] v;
        @(negedge clk); port_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd3, v); chk("R7 change not yet latched", v, 8'h00);
        @(negedge clk);
        rd(2'd3, v); chk("R7 change flag third edge", v, 8'h20);
        chk("R5 port change no wake", wake, 1'b0);
        wr(2'd3, 8'h00);
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R7 steady port no flag", v, 8'h00);
        @(negedge clk); port_in = 4'b1011;
        repeat (3) @(negedge clk);
        rd(2'd3, v); chk("R7 multi-bit change one flag", v, 8'h20);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h20); wr(2'd0, 8'h20);
        chk("R8 no request after clear", irq_lo, 1'b0);
        @(negedge clk); port_in = 4'b0000;
        repeat (3) @(negedge clk);
        chk("R7 change drives low request", {irq_hi, irq_lo}, 2'b01);
        wr(2'd3, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_ext_edges;
        t_sticky;
        t_enable_prio;
        t_pin0;
        t_timer;
        t_set_wins;
        t_port_change;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule